// File: doc/BRIEF.md
# Serially loaded shift-register lookup memory

This block is a read-only lookup table of 2^ADDR_W words, each DATA_W bits wide. Its storage is made only of small 16-bit addressable shift-register cells. Each cell shifts in one bit on every clock in which the serial enable is high. A 4-bit tap select picks which of the cell's 16 positions drives its output, with no clock involved. Each data bit has its own column of cells. When the depth is more than 16 words, a column is a string of cells joined end to end.

There is no write-address port. The contents are changed at run time by shifting a new image through one serial chain that runs through every column. The serial data and the serial enable are passed on to output ports, so several blocks can be strung together and loaded from one bit stream. A lookup engine drives the read address. It gets a word back in the same cycle, through the cell taps and the multiplexer that selects the cell.

Top module: `srl_lut_mem`

## Requirements
- R1: While rst_n is low, every cell is cleared. After reset, every address reads all zeros and ser_dout is 0.
- R2: Each stored bit has a chain position p = c*2^ADDR_W + a, where c is the column (data bit) and a is the address. On every rising clock edge with ser_en_in high, ser_din enters position 0 (address 0 of column 0), and the bit at each position p moves to position p+1.
- R3: Let M bits have been shifted since reset, with s[M-1] the most recent. The bit at position p (rd_data[c] at rd_addr = a) equals s[M-1-p] when p < M, and is 0 otherwise. A full load of DATA_W*2^ADDR_W bits therefore fills the whole memory, and its last bit lands at address 0 of column 0.
- R4: rd_data follows rd_addr combinationally. A new address gives its word in the same cycle, with no clock edge between them.
- R5: While ser_en_in is low, all contents and ser_dout hold their values, whatever ser_din does.
- R6: ser_dout carries the bit at the last chain position (column DATA_W-1, address 2^ADDR_W-1). This is the bit that entered DATA_W*2^ADDR_W enabled shifts earlier.
- R7: ser_en_out equals ser_en_in in the same cycle.
- R8: A second full load at run time replaces every word with the new image.
- R9: Reads made partway through a load return the partly shifted contents given by R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all cells |
| ser_din | input | 1 | Serial load data |
| ser_en_in | input | 1 | Serial load enable; shifts the whole chain when high |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Word at rd_addr; bit c comes from column c |
| ser_dout | output | 1 | Bit leaving the end of the chain, for the next block |
| ser_en_out | output | 1 | Serial enable passed on to the next block |

## Verification
The assertions are checked on every cycle. They cover four behaviours: a new bit appears at address 0 of column 0 after an enabled edge, the memory holds its word while the enable is low and the address is unchanged, the word read at the top address agrees with ser_dout, and the memory reads all zeros when reset is released. The bench scenarios cover the rest. The full chain ordering across columns and cells, replacement by a second load, the contents partway through a load, and ser_dout emerging exactly one chain length later can only be shown by sweeping every address against the shift history.

// File: rtl/srlm_pkg.sv
package srlm_pkg;
  // Address bits resolved inside one shift cell; a cell holds 2**CELL_AW bits.
  localparam int unsigned CELL_AW = 4;

  function automatic int unsigned cell_sel_w(input int unsigned addr_w);
    return (addr_w < CELL_AW) ? addr_w : CELL_AW;
  endfunction
endpackage

// File: rtl/srlm_cell.sv
module srlm_cell #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sin,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tap_out,
  output logic             sout
);
  localparam int unsigned LEN = 1 << SEL_W;

  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;

  // Position 0 holds the newest bit.
  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      sr_d = {sr_q[LEN-2:0], sin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign tap_out = sr_q[tap_sel];
  assign sout    = sr_q[LEN-1];
endmodule

// File: rtl/srlm_column.sv
module srlm_column
  import srlm_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sin,
  input  logic [ADDR_W-1:0] addr,
  output logic              dout,
  output logic              sout
);
  localparam int unsigned SEL_W = cell_sel_w(ADDR_W);
  localparam int unsigned HI_W  = ADDR_W - SEL_W;
  localparam int unsigned CELLS = 1 << HI_W;

  logic [CELLS:0]   chain;
  logic [CELLS-1:0] taps;

  assign chain[0] = sin;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    srlm_cell #(.SEL_W(SEL_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .sin      (chain[k]),
      .tap_sel  (addr[SEL_W-1:0]),
      .tap_out  (taps[k]),
      .sout     (chain[k+1])
    );
  end

  if (HI_W == 0) begin : g_single
    assign dout = taps[0];
  end else begin : g_multi
    // Upper address bits choose the cell, lower bits the tap within it.
    assign dout = taps[addr[ADDR_W-1:SEL_W]];
  end

  assign sout = chain[CELLS];
endmodule

// File: rtl/srl_lut_mem.sv
module srl_lut_mem #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_din,
  input  logic              ser_en_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ser_dout,
  output logic              ser_en_out
);
  // Column c's last bit feeds column c+1's first bit.
  logic [DATA_W:0] link;

  assign link[0] = ser_din;

  for (genvar c = 0; c < DATA_W; c++) begin : g_col
    srlm_column #(.ADDR_W(ADDR_W)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (ser_en_in),
      .sin      (link[c]),
      .addr     (rd_addr),
      .dout     (rd_data[c]),
      .sout     (link[c+1])
    );
  end

  assign ser_dout   = link[DATA_W];
  assign ser_en_out = ser_en_in;
endmodule

// File: rtl/srlm_checker.sv
module srlm_checker #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_din,
  input logic              ser_en_in,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              ser_dout
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0 && ser_dout == 1'b0)); // R1

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ser_en_in) && rd_addr == '0) |-> rd_data[0] == $past(ser_din)); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ser_en_in) && $stable(rd_addr)) |-> ($stable(rd_data) && $stable(ser_dout))); // R5

  AST_CHAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '1) |-> rd_data[DATA_W-1] == ser_dout); // R6
endmodule

bind srl_lut_mem srlm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_din   (ser_din),
  .ser_en_in (ser_en_in),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .ser_dout  (ser_dout)
);

// File: tb/sim_srl_lut_mem.sv
`timescale 1ns/1ps
module sim_srl_lut_mem;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TOTAL  = DEPTH * DATA_W;
  localparam int HIST   = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_din = 1'b0;
  logic ser_en_in = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic ser_dout;
  logic ser_en_out;

  int checks = 0;
  int fails = 0;
  int nshift = 0;
  bit hist [HIST];

  always #(CLK_PERIOD/2) clk = ~clk;

  srl_lut_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_en_in(ser_en_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .ser_dout(ser_dout),
    .ser_en_out(ser_en_out)
  );

  // Expected bit at chain position p, per the shift history (R3).
  function automatic bit exp_pos(input int p);
    if (p < nshift) return hist[nshift-1-p];
    return 1'b0;
  endfunction

  function automatic bit pat(input int seed, input int i);
    return 1'(((i * (2*seed + 5)) ^ (i >> 3) ^ seed ^ (i >> 1)) & 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One enabled shift; ser_dout and ser_en_out checked before the edge.
  task automatic shift_bit(input bit b);
    @(negedge clk);
    ser_din = b;
    ser_en_in = 1'b1;
    #1;
    check(ser_en_out == 1'b1, "R7", int'(ser_en_out), 1);
    check(ser_dout == exp_pos(TOTAL-1), "R6", int'(ser_dout), int'(exp_pos(TOTAL-1)));
    @(posedge clk);
    hist[nshift] = b;
    nshift++;
    @(negedge clk);
    ser_en_in = 1'b0;
  endtask

  // Sweep every address with enable low and ser_din toggling.
  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      logic [DATA_W-1:0] e;
      @(negedge clk);
      ser_din = ~ser_din;
      rd_addr = ADDR_W'(a);
      #1;
      for (int c = 0; c < DATA_W; c++) e[c] = exp_pos(c*DEPTH + a);
      check(rd_data == e, req, int'(rd_data), int'(e));
      check(ser_en_out == 1'b0, "R7", int'(ser_en_out), 0);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    sweep("R1");
    check(ser_dout == 1'b0, "R1", int'(ser_dout), 0);
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    // Full load of a first image (R2, R3).
    for (int i = 0; i < TOTAL; i++) shift_bit(pat(1, i));
    sweep("R3");
    // Held contents with enable low and toggling data (R5).
    repeat (7) begin
      @(negedge clk);
      ser_din = ~ser_din;
    end
    sweep("R5");

    // Combinational read: change address mid-cycle, no edge (R4).
    @(negedge clk);
    rd_addr = ADDR_W'(3);
    #1;
    rd_addr = ADDR_W'(DEPTH-2);
    #1;
    begin
      logic [DATA_W-1:0] e;
      for (int c = 0; c < DATA_W; c++) e[c] = exp_pos(c*DEPTH + DEPTH-2);
      check(rd_data == e, "R4", int'(rd_data), int'(e));
    end

    // Partial shifts mid-load (R9), address 0 tracking new bits (R2).
    for (int i = 0; i < 37; i++) shift_bit(pat(2, i));
    sweep("R9");

    // Complete reload with a second image (R8).
    for (int i = 0; i < TOTAL; i++) shift_bit(pat(3, i));
    sweep("R8");
    for (int i = 0; i < TOTAL; i++) shift_bit(1'b1);
    sweep("R8");
    for (int i = 0; i < 5; i++) shift_bit(1'b0);
    sweep("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule